// File: doc/BRIEF.md
# Gated Serial Bitstream Receiver

This block takes a compressed audio bitstream from a two-wire serial link, a data line and a receive clock, and assembles it into bytes for a decoder running on the system clock. Both serial wires and a bit-gate input pass through two-flop synchronisers. The sampling edge is found in the system clock domain, so the receive clock must run at no more than a quarter of the system clock rate. A configuration input picks whether the rising or the falling receive-clock edge captures each bit.

Completed bytes go into a small byte FIFO. The FIFO feeds the decoder through a ready/valid port. A data-request output tells the bitstream source whether at least one FIFO slot is free. The gate input can pause reception in the middle of a byte without losing bits already captured. A change of the gate while the receive clock is high is a protocol violation and is flagged. Bytes that arrive while the FIFO is full are dropped and flagged. One clear input resets both sticky flags.

Top module: `bsrx_top`

## Requirements
- R1: Bits are taken most-significant first: the first bit captured after a byte boundary ends up in out_data[7].
- R2: With edge_sel = 0, data is captured on rising ser_clk edges. With edge_sel = 1, data is captured on falling edges. The data level at the other edge has no effect.
- R3: While bit_gate is low, ser_clk edges neither shift nor count bits. A byte paused this way resumes at its bit position once bit_gate returns high.
- R4: A bit_gate change seen while ser_clk is high sets the sticky proto_err output. A change while ser_clk is low leaves proto_err unchanged.
- R5: data_req is 1 while the FIFO (4 entries by default) has a free entry. It is 0 while the FIFO holds 4 bytes.
- R6: A byte completed while the FIFO is full is discarded and sets the sticky overflow output. A one-cycle pulse on clr_flags clears both overflow and proto_err.
- R7: A byte leaves the FIFO in a cycle where out_valid and out_ready are both 1. Bytes leave in arrival order. out_data holds steady while out_valid is 1 and out_ready is 0.
- R8: After a synchronous reset (rst_n low at a clock edge), out_valid = 0, data_req = 1 and overflow = proto_err = 0, and any partly assembled byte is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk | input | 1 | Serial receive clock, asynchronous |
| ser_dat | input | 1 | Serial data line, asynchronous |
| bit_gate | input | 1 | Reception enable; change only while ser_clk is low |
| edge_sel | input | 1 | 0 = rising-edge capture, 1 = falling-edge capture |
| clr_flags | input | 1 | Clears overflow and proto_err |
| data_req | output | 1 | Source may send more data |
| out_data | output | 8 | Head byte of the FIFO |
| out_valid | output | 1 | FIFO holds at least one byte |
| out_ready | input | 1 | Consumer accepts the head byte |
| overflow | output | 1 | Sticky: a byte was dropped |
| proto_err | output | 1 | Sticky: bit_gate changed while ser_clk was high |

## Verification
The bench drives the data line to the inverse value around the edge that should not capture, and to the real value around the edge that should. A receiver that samples the wrong edge therefore delivers bit-inverted bytes. A pause in mid-byte feeds junk bits while the gate is low. A receiver that counts or shifts them returns a misaligned byte or an extra byte. With the consumer stalled, a fifth byte overfills the FIFO. A design that overwrote the oldest entry, or that kept data_req high, would show a wrong byte order or a wrong flag. A reset in the middle of a byte checks that leftover bits do not leak into the next byte. A gate change under a high clock checks the protocol flag, and a legal pause checks that the flag stays low.

// File: rtl/bsrx_pkg.sv
// Shared widths and the byte type of the serial bitstream receiver.
package bsrx_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bsrx_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent and stable for several clk cycles per level.
module bsrx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift each stage one step toward the output.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_in;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/bsrx_shifter.sv
// Edge detector, gating logic and MSB-first byte assembler.
// Inputs are already synchronised. The serial clock must be at most clk/4,
// so that every level lasts at least two samples. Also watches the gate for
// changes while the serial clock is high.
module bsrx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_s,
    input  logic         dat_s,
    input  logic         gate_s,
    input  logic         edge_sel,
    input  logic         clr,
    output logic         byte_done,
    output logic [W-1:0] byte_val,
    output logic         perr
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W-1);

    logic          sclk_d, gate_d;
    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;
    logic          sample, take;

    // Pick the capturing edge from the previous and current clock samples.
    always_comb begin
        sample = edge_sel ? (sclk_d & ~sclk_s) : (sclk_s & ~sclk_d);
        take   = sample & gate_s;
    end

    // Delay registers used for edge and gate-change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            gate_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            gate_d <= gate_s;
        end
    end

    // Shift accepted bits in and advance the bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (take) begin
            sh_q  <= {sh_q[W-2:0], dat_s};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sticky flag for a gate change while the serial clock is high.
    always_ff @(posedge clk) begin
        if (!rst_n) perr <= 1'b0;
        else if (gate_s != gate_d && sclk_s) perr <= 1'b1;
        else if (clr) perr <= 1'b0;
    end

    assign byte_done = take && (cnt_q == LAST);
    assign byte_val  = {sh_q[W-2:0], dat_s};

    // R3
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !gate_s) |=> $stable(cnt_q) && $stable(sh_q));
    // R4
    perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr) |-> $past(sclk_s && (gate_s != gate_d)));
endmodule

// File: rtl/bsrx_fifo.sv
// Byte FIFO between the assembler and the decoder port. Power-of-two depth.
// A write while full is dropped and sets a sticky overflow flag.
module bsrx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full,
    input  logic         clr,
    output logic         ovf
);
    localparam int PW = $clog2(DEPTH);
    localparam int NW = $clog2(DEPTH+1);
    localparam logic [NW-1:0] FULL_N = NW'(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [NW-1:0] n_q;
    logic          push, pop;

    assign empty = (n_q == '0);
    assign full  = (n_q == FULL_N);
    assign push  = wr_en && !full;
    assign pop   = rd_en && !empty;

    // Store an accepted byte in its slot.
    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
            n_q  <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            if (push && !pop)      n_q <= n_q + 1'b1;
            else if (pop && !push) n_q <= n_q - 1'b1;
        end
    end

    // Sticky record of a dropped byte.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else if (wr_en && full) ovf <= 1'b1;
        else if (clr) ovf <= 1'b0;
    end

    assign rd_data = mem_q[rp_q];

    // R5
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        n_q <= FULL_N);
    // R6
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(wr_en && full));
    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !rd_en) |=> !empty && $stable(rd_data));
endmodule

// File: rtl/bsrx_top.sv
// Gated serial bitstream receiver: synchronises the link, assembles bytes
// MSB first and buffers them for a ready/valid consumer.
// Assumes the serial clock is at most a quarter of clk.
module bsrx_top
    import bsrx_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_dat,
    input  logic        bit_gate,
    input  logic        edge_sel,
    input  logic        clr_flags,
    output logic        data_req,
    output logic [7:0]  out_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        overflow,
    output logic        proto_err
);
    logic [2:0] raw_in, sync_out;
    logic       byte_done, fifo_empty, fifo_full;
    byte_t      byte_val;

    assign raw_in = {bit_gate, ser_dat, ser_clk};

    bsrx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(raw_in), .d_out(sync_out)
    );

    bsrx_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(sync_out[0]), .dat_s(sync_out[1]), .gate_s(sync_out[2]),
        .edge_sel(edge_sel), .clr(clr_flags),
        .byte_done(byte_done), .byte_val(byte_val), .perr(proto_err)
    );

    bsrx_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(byte_done), .wr_data(byte_val),
        .rd_en(out_ready), .rd_data(out_data),
        .empty(fifo_empty), .full(fifo_full),
        .clr(clr_flags), .ovf(overflow)
    );

    assign out_valid = !fifo_empty;
    assign data_req  = !fifo_full;

    // R5
    req_vs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_req |-> out_valid);
endmodule

// File: tb/sim_bsrx_top.sv
module sim_bsrx_top;
    localparam int H = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, bit_gate = 1'b1;
    logic edge_sel = 1'b0, clr_flags = 1'b0, out_ready = 1'b1;
    logic data_req, out_valid, overflow, proto_err;
    logic [7:0] out_data;

    bsrx_top u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .bit_gate(bit_gate), .edge_sel(edge_sel), .clr_flags(clr_flags),
        .data_req(data_req), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .overflow(overflow), .proto_err(proto_err)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive the inverse value at the non-capturing edge (R2).
    task automatic send_bit(input logic b);
        ser_dat = edge_sel ? ~b : b;
        wait_cyc(H);
        ser_clk = 1'b1;
        wait_cyc(1);
        ser_dat = edge_sel ? b : ~b;
        wait_cyc(H-1);
        ser_clk = 1'b0;
        wait_cyc(1);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit kept);
        if (kept) exp_q.push_back(v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        wait_cyc(6);
    endtask

    // Scoreboard monitor: compare every popped byte.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) chk(1'b0, "R7 unexpected byte", out_data, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(out_data == e, "R1 R2 R7 byte value/order", out_data, e);
            end
        end
    end

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        // R8 reset state
        chk(out_valid == 0, "R8 out_valid", out_valid, 0);
        chk(data_req == 1, "R8 data_req", data_req, 1);
        chk(overflow == 0 && proto_err == 0, "R8 flags", {overflow, proto_err}, 0);

        // R1 rising-edge capture
        send_byte(8'hA5, 1); send_byte(8'h3C, 1); send_byte(8'h01, 1);
        wait_cyc(4);
        // R2 falling-edge capture
        edge_sel = 1'b1; wait_cyc(2);
        send_byte(8'hC3, 1); send_byte(8'h80, 1); send_byte(8'h7E, 1);
        edge_sel = 1'b0; wait_cyc(4);
        chk(exp_q.size() == 0, "R2 all bytes delivered", exp_q.size(), 0);

        // R3 pause mid-byte with junk bits while gated
        exp_q.push_back(8'h9B);
        for (int i = 7; i >= 4; i--) send_bit(8'h9B >> i);
        bit_gate = 1'b0; wait_cyc(3);
        for (int i = 0; i < 5; i++) send_bit(i[0]);
        bit_gate = 1'b1; wait_cyc(3);
        for (int i = 3; i >= 0; i--) send_bit(8'h9B >> i);
        wait_cyc(8);
        chk(exp_q.size() == 0, "R3 paused byte delivered", exp_q.size(), 0);
        chk(proto_err == 0, "R4 legal gate change", proto_err, 0);

        // R4 gate change while clock high (falling mode so nothing captured)
        edge_sel = 1'b1; wait_cyc(2);
        ser_clk = 1'b1; wait_cyc(3);
        bit_gate = 1'b0; wait_cyc(3);
        ser_clk = 1'b0; wait_cyc(3);
        bit_gate = 1'b1; wait_cyc(4);
        chk(proto_err == 1, "R4 illegal gate change", proto_err, 1);
        clr_flags = 1'b1; wait_cyc(1); clr_flags = 1'b0; wait_cyc(1);
        chk(proto_err == 0, "R6 clear proto_err", proto_err, 0);
        edge_sel = 1'b0; wait_cyc(2);
        send_byte(8'h5A, 1);
        wait_cyc(4);
        chk(exp_q.size() == 0, "R3 no stray bits after gating", exp_q.size(), 0);

        // R5/R6 overflow with stalled consumer
        out_ready = 1'b0;
        send_byte(8'h11, 1); send_byte(8'h22, 1); send_byte(8'h33, 1);
        chk(data_req == 1, "R5 data_req with free slot", data_req, 1);
        send_byte(8'h44, 1);
        chk(data_req == 0, "R5 data_req when full", data_req, 0);
        chk(out_valid == 1 && out_data == 8'h11, "R7 head held", out_data, 8'h11);
        send_byte(8'h55, 0);
        chk(overflow == 1, "R6 overflow set", overflow, 1);
        clr_flags = 1'b1; wait_cyc(1); clr_flags = 1'b0; wait_cyc(1);
        chk(overflow == 0, "R6 overflow cleared", overflow, 0);
        out_ready = 1'b1; wait_cyc(8);
        chk(exp_q.size() == 0, "R6 kept bytes drained", exp_q.size(), 0);
        chk(data_req == 1, "R5 data_req after drain", data_req, 1);

        // R8 reset in mid-byte
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        rst_n = 1'b0; wait_cyc(2); rst_n = 1'b1; wait_cyc(2);
        send_byte(8'h0F, 1);
        wait_cyc(4);
        chk(exp_q.size() == 0, "R8 partial byte discarded", exp_q.size(), 0);
        report();
    end
endmodule